// File: doc/BRIEF.md
# Integer Execute and Immediate Unit

This block is the purely combinational execute step of a 32-bit register-machine pipeline. Each cycle it is handed one instruction word and the two source register values already read from the register file. It decodes the instruction and returns everything the next stages need: an integer result, the index of the register to write, a write strobe, and, for memory instructions, an effective address, a direction and an access size.

The block handles two encodings. The register format carries the operation in a function field and names its destination in the rd field. The immediate format carries a 16-bit constant and names its destination in the rt field. Per instruction, the immediate is sign-extended, zero-extended or moved into the upper half of the word. Signed add and subtract report two's-complement overflow and cancel their write. The unsigned forms never do. Encodings the block does not support raise an illegal flag and cause no side effect.

Top module: `int_exec_unit`

## Requirements
- R1: Register format (opcode 000000, fields rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]) writes rd. Function 100000 adds rs+rt and 100001 adds without overflow detection. Function 100010 computes rs−rt and 100011 subtracts without overflow detection.
- R2: Function 100100 gives AND, 100101 gives OR, 100110 gives XOR and 100111 gives NOR of rs and rt.
- R3: Function 101010 gives 1 when rs<rt as signed numbers and 0 otherwise. Function 101011 does the same comparison as unsigned numbers.
- R4: Immediate opcodes write rt. 001000 (add, overflow-checked) and 001001 (add, unchecked) add rs to the sign-extended immediate in bits [15:0]. 001010 sets 1 on signed rs < sign-extended immediate. 001011 compares rs with the sign-extended immediate as unsigned numbers.
- R5: Opcodes 001100, 001101 and 001110 give AND, OR and XOR of rs with the zero-extended immediate.
- R6: Opcode 001111 returns the immediate in bits [31:16] with bits [15:0] zero, written to rt.
- R7: Loads (opcodes 100000, 100001, 100011) drive mem_rd, the address rs+sign-extended offset on both mem_addr and result, mem_size 0/1/2 for byte/half/word, and a write to rt.
- R8: Stores (opcodes 101000, 101001, 101011) drive mem_wr, the same address and size coding, dest_idx 0 and no register write. mem_rd and mem_wr are never both high.
- R9: Checked add, subtract and add-immediate raise ovf on signed overflow, and ovf blocks rf_we. The unchecked forms never raise ovf.
- R10: When the selected destination index is 0, rf_we stays low.
- R11: Any other opcode, any other function code, or a register-format word with nonzero shamt raises illegal. It then drives rf_we, mem_rd, mem_wr and ovf low and dest_idx, result, mem_addr and mem_size to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of register named by bits [25:21] |
| rt_val | input | 32 | Value of register named by bits [20:16] |
| result | output | 32 | ALU result, or effective address for memory instructions |
| dest_idx | output | 5 | Destination register index |
| rf_we | output | 1 | Register write strobe |
| mem_addr | output | 32 | Effective address |
| mem_rd | output | 1 | Load request |
| mem_wr | output | 1 | Store request |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| ovf | output | 1 | Signed overflow on checked add/subtract |
| illegal | output | 1 | Unsupported encoding |

## Verification
Random instruction words almost never produce signed overflow. They also rarely hit a zero destination together with a legal opcode, or an unsigned-immediate compare whose sign-extended constant wraps to a large unsigned value. The stimulus therefore builds its words from the legal opcode and function lists. It draws operands with high probability from the boundary set 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. It forces register index 0 into the destination fields often enough that these cases each occur many times. Directed vectors come first and pin each of those cases explicitly.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int RIDX_W = 5;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_LD_B  = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_LD_H  = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_LD_W  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_ST_B  = 6'b101000;
  localparam logic [OPC_W-1:0] OPC_ST_H  = 6'b101001;
  localparam logic [OPC_W-1:0] OPC_ST_W  = 6'b101011;

  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_SLT, OP_SLTU, OP_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SEXT, IMM_ZEXT, IMM_HIGH
  } imm_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2
  } mem_size_e;

  typedef struct packed {
    logic      legal;
    alu_op_e   op;
    logic      use_imm;
    imm_mode_e imm_mode;
    logic      dst_is_rd;
    logic      writes;
    logic      chk_ovf;
    logic      is_load;
    logic      is_store;
    mem_size_e size;
  } ctrl_t;

  // Signed overflow of a sum: operands agree in sign, sum does not.
  function automatic logic add_overflow(input logic a_msb, input logic b_msb,
                                        input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Signed overflow of a difference: operands differ in sign, result sign flips from a.
  function automatic logic sub_overflow(input logic a_msb, input logic b_msb,
                                        input logic d_msb);
    return (a_msb != b_msb) && (d_msb != a_msb);
  endfunction

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [5:0]       funct,
  input  logic [4:0]       shamt,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.op       = OP_ADD;
    ctrl.imm_mode = IMM_SEXT;
    ctrl.size     = SZ_BYTE;
    unique case (opcode)
      OPC_REG: begin
        ctrl.legal     = (shamt == 5'd0);
        ctrl.dst_is_rd = 1'b1;
        ctrl.writes    = 1'b1;
        unique case (funct)
          FN_ADD:  begin ctrl.op = OP_ADD;  ctrl.chk_ovf = 1'b1; end
          FN_ADDU: ctrl.op = OP_ADD;
          FN_SUB:  begin ctrl.op = OP_SUB;  ctrl.chk_ovf = 1'b1; end
          FN_SUBU: ctrl.op = OP_SUB;
          FN_AND:  ctrl.op = OP_AND;
          FN_OR:   ctrl.op = OP_OR;
          FN_XOR:  ctrl.op = OP_XOR;
          FN_NOR:  ctrl.op = OP_NOR;
          FN_SLT:  ctrl.op = OP_SLT;
          FN_SLTU: ctrl.op = OP_SLTU;
          default: ctrl.legal = 1'b0;
        endcase
      end
      OPC_ADDI, OPC_ADDIU, OPC_SLTI, OPC_SLTIU,
      OPC_ANDI, OPC_ORI, OPC_XORI, OPC_LUI: begin
        ctrl.legal   = 1'b1;
        ctrl.writes  = 1'b1;
        ctrl.use_imm = 1'b1;
        unique case (opcode[2:0])
          3'b000: begin ctrl.op = OP_ADD; ctrl.chk_ovf = 1'b1; end
          3'b001: ctrl.op = OP_ADD;
          3'b010: ctrl.op = OP_SLT;
          3'b011: ctrl.op = OP_SLTU;
          3'b100: begin ctrl.op = OP_AND; ctrl.imm_mode = IMM_ZEXT; end
          3'b101: begin ctrl.op = OP_OR;  ctrl.imm_mode = IMM_ZEXT; end
          3'b110: begin ctrl.op = OP_XOR; ctrl.imm_mode = IMM_ZEXT; end
          default: begin ctrl.op = OP_PASSB; ctrl.imm_mode = IMM_HIGH; end
        endcase
      end
      OPC_LD_B, OPC_LD_H, OPC_LD_W: begin
        ctrl.legal   = 1'b1;
        ctrl.writes  = 1'b1;
        ctrl.is_load = 1'b1;
        ctrl.size    = (opcode[1:0] == 2'b00) ? SZ_BYTE :
                       (opcode[1:0] == 2'b01) ? SZ_HALF : SZ_WORD;
      end
      OPC_ST_B, OPC_ST_H, OPC_ST_W: begin
        ctrl.legal    = 1'b1;
        ctrl.is_store = 1'b1;
        ctrl.size     = (opcode[1:0] == 2'b00) ? SZ_BYTE :
                        (opcode[1:0] == 2'b01) ? SZ_HALF : SZ_WORD;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_exec_immgen.sv
module int_exec_immgen
  import int_exec_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_BITS = IMM_W
) (
  input  logic [IMM_BITS-1:0] imm,
  input  imm_mode_e           mode,
  output logic [DATA_W-1:0]   imm_ext
);

  localparam int PAD_W = DATA_W - IMM_BITS;

  logic [DATA_W-1:0] sext_v, zext_v, high_v;

  generate
    if (PAD_W > 0) begin : g_pad
      assign sext_v = {{PAD_W{imm[IMM_BITS-1]}}, imm};
      assign zext_v = {{PAD_W{1'b0}}, imm};
      assign high_v = {imm, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign sext_v = imm;
      assign zext_v = imm;
      assign high_v = imm;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      IMM_ZEXT: imm_ext = zext_v;
      IMM_HIGH: imm_ext = high_v;
      default:  imm_ext = sext_v;
    endcase
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y,
  output logic              ovf_evt
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum_v, diff_v;
  logic              lt_s, lt_u;

  assign sum_v  = a + b;
  assign diff_v = a - b;
  assign lt_s   = $signed(a) < $signed(b);
  assign lt_u   = a < b;

  always_comb begin
    y       = '0;
    ovf_evt = 1'b0;
    unique case (op)
      OP_ADD: begin
        y       = sum_v;
        ovf_evt = add_overflow(a[MSB], b[MSB], sum_v[MSB]);
      end
      OP_SUB: begin
        y       = diff_v;
        ovf_evt = sub_overflow(a[MSB], b[MSB], diff_v[MSB]);
      end
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      OP_SLT:  y = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU: y = {{(DATA_W-1){1'b0}}, lt_u};
      default: y = b;
    endcase
  end

endmodule

// File: rtl/int_exec_agu.sv
module int_exec_agu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  output logic [DATA_W-1:0] addr
);

  assign addr = base + offset;

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int REG_IDX_W = RIDX_W
) (
  input  logic [31:0]          instr,
  input  logic [DATA_W-1:0]    rs_val,
  input  logic [DATA_W-1:0]    rt_val,
  output logic [DATA_W-1:0]    result,
  output logic [REG_IDX_W-1:0] dest_idx,
  output logic                 rf_we,
  output logic [DATA_W-1:0]    mem_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [1:0]           mem_size,
  output logic                 ovf,
  output logic                 illegal
);

  // Instruction fields
  logic [OPC_W-1:0]     f_opc;
  logic [REG_IDX_W-1:0] f_rt, f_rd;
  logic [4:0]           f_shamt;
  logic [5:0]           f_funct;
  logic [IMM_W-1:0]     f_imm;

  assign f_opc   = instr[31:26];
  assign f_rt    = instr[20:16];
  assign f_rd    = instr[15:11];
  assign f_shamt = instr[10:6];
  assign f_funct = instr[5:0];
  assign f_imm   = instr[15:0];

  ctrl_t             ctrl;
  logic [DATA_W-1:0] imm_ext, opnd_b, alu_y, eff_addr;
  logic              alu_ovf_evt;

  // Named internal events
  logic                 is_mem;
  logic [REG_IDX_W-1:0] dst_sel;
  logic                 dst_is_zero;
  logic                 ovf_event;

  int_exec_decode u_dec (
    .opcode (f_opc),
    .funct  (f_funct),
    .shamt  (f_shamt),
    .ctrl   (ctrl)
  );

  int_exec_immgen #(.DATA_W(DATA_W), .IMM_BITS(IMM_W)) u_imm (
    .imm     (f_imm),
    .mode    (ctrl.imm_mode),
    .imm_ext (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : rt_val;

  int_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .a       (rs_val),
    .b       (opnd_b),
    .op      (ctrl.op),
    .y       (alu_y),
    .ovf_evt (alu_ovf_evt)
  );

  int_exec_agu #(.DATA_W(DATA_W)) u_agu (
    .base   (rs_val),
    .offset (imm_ext),
    .addr   (eff_addr)
  );

  assign is_mem      = ctrl.is_load | ctrl.is_store;
  assign dst_sel     = ctrl.dst_is_rd ? f_rd : f_rt;
  assign dst_is_zero = (dst_sel == '0);
  assign ovf_event   = ctrl.legal & ctrl.chk_ovf & alu_ovf_evt;

  assign illegal  = ~ctrl.legal;
  assign ovf      = ovf_event;
  assign mem_rd   = ctrl.legal & ctrl.is_load;
  assign mem_wr   = ctrl.legal & ctrl.is_store;
  assign mem_size = (ctrl.legal & is_mem) ? ctrl.size : 2'd0;
  assign mem_addr = (ctrl.legal & is_mem) ? eff_addr : '0;
  assign result   = ~ctrl.legal ? '0 : (is_mem ? eff_addr : alu_y);
  assign dest_idx = (ctrl.legal & ctrl.writes) ? dst_sel : '0;
  assign rf_we    = ctrl.legal & ctrl.writes & ~dst_is_zero & ~ovf_event;

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk (
  input logic [31:0] instr,
  input logic [31:0] result,
  input logic [4:0]  dest_idx,
  input logic        rf_we,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        ovf,
  input logic        illegal
);

  logic is_lui, is_cmp_reg;
  assign is_lui     = (instr[31:26] == 6'b001111);
  assign is_cmp_reg = (instr[31:26] == 6'b000000) &&
                      ((instr[5:0] == 6'b101010) || (instr[5:0] == 6'b101011));

  always_comb begin
    // R10
    p_zero_dest_no_write_r10: assert (!(dest_idx == 5'd0 && rf_we))
      else $error("zero destination written");
    // R11
    p_illegal_quiet_r11: assert (!(illegal && (rf_we || mem_rd || mem_wr || ovf)))
      else $error("illegal instruction had a side effect");
    // R9
    p_ovf_blocks_write_r9: assert (!(ovf && rf_we))
      else $error("overflow did not cancel write");
    // R8
    p_mem_exclusive_r8: assert (!(mem_rd && mem_wr))
      else $error("load and store together");
    // R6
    p_lui_low_zero_r6: assert (!(is_lui && !illegal && result[15:0] != 16'd0))
      else $error("upper-immediate low half not zero");
    // R3
    p_cmp_boolean_r3: assert (!(is_cmp_reg && !illegal && result[31:1] != 31'd0))
      else $error("compare result not 0 or 1");
  end

endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
  .instr    (instr),
  .result   (result),
  .dest_idx (dest_idx),
  .rf_we    (rf_we),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .ovf      (ovf),
  .illegal  (illegal)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] result, mem_addr;
  logic [4:0]  dest_idx;
  logic        rf_we, mem_rd, mem_wr, ovf, illegal;
  logic [1:0]  mem_size;

  int_exec_unit u_int_exec_unit (
    .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(result), .dest_idx(dest_idx), .rf_we(rf_we),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_size(mem_size), .ovf(ovf), .illegal(illegal)
  );

  typedef struct packed {
    logic [31:0] res;
    logic [4:0]  dst;
    logic        we;
    logic [31:0] addr;
    logic        rd;
    logic        wr;
    logic [1:0]  sz;
    logic        ov;
    logic        ill;
  } obs_t;

  typedef struct {
    logic [31:0] i;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  vec_t vq[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] opc, int rs, int rt, logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic string tag_of(logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    if (op == 6'd0) begin
      if (ins[10:6] != 0) return "R11";
      case (fn)
        6'h20, 6'h21, 6'h22, 6'h23: return "R1/R9";
        6'h24, 6'h25, 6'h26, 6'h27: return "R2";
        6'h2a, 6'h2b:               return "R3";
        default:                    return "R11";
      endcase
    end
    case (op)
      6'h08, 6'h09, 6'h0a, 6'h0b: return "R4/R9";
      6'h0c, 6'h0d, 6'h0e:        return "R5";
      6'h0f:                      return "R6";
      6'h20, 6'h21, 6'h23:        return "R7";
      6'h28, 6'h29, 6'h2b:        return "R8";
      default:                    return "R11";
    endcase
  endfunction

  // Behavioural reference written from the requirements
  function automatic obs_t model(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    obs_t e = '0;
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    int rt = int'(ins[20:16]);
    int rd = int'(ins[15:11]);
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] zx = {16'h0, ins[15:0]};
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ssx = longint'($signed(sx));
    longint wide;
    bit has_dst = 0;
    int dst = 0;
    e.ill = 1;
    if (op == 6'd0 && ins[10:6] == 0) begin
      e.ill = 0; has_dst = 1; dst = rd;
      case (fn)
        6'h20: begin wide = sa + sb; e.res = a + b; e.ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h21: e.res = a + b;
        6'h22: begin wide = sa - sb; e.res = a - b; e.ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h23: e.res = a - b;
        6'h24: e.res = a & b;
        6'h25: e.res = a | b;
        6'h26: e.res = a ^ b;
        6'h27: e.res = ~(a | b);
        6'h2a: e.res = (sa < sb) ? 32'd1 : 32'd0;
        6'h2b: e.res = (a < b) ? 32'd1 : 32'd0;
        default: begin e.ill = 1; has_dst = 0; end
      endcase
    end else if (op[5:3] == 3'b001) begin
      e.ill = 0; has_dst = 1; dst = rt;
      case (op[2:0])
        3'd0: begin wide = sa + ssx; e.res = a + sx; e.ov = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        3'd1: e.res = a + sx;
        3'd2: e.res = (sa < ssx) ? 32'd1 : 32'd0;
        3'd3: e.res = (a < sx) ? 32'd1 : 32'd0;
        3'd4: e.res = a & zx;
        3'd5: e.res = a | zx;
        3'd6: e.res = a ^ zx;
        default: e.res = zx * 32'd65536;
      endcase
    end else if ((op[5:3] == 3'b100 || op[5:3] == 3'b101) &&
                 (op[2:0] == 3'd0 || op[2:0] == 3'd1 || op[2:0] == 3'd3)) begin
      e.ill  = 0;
      e.addr = a + sx;
      e.res  = e.addr;
      e.sz   = (op[2:0] == 3'd0) ? 2'd0 : (op[2:0] == 3'd1) ? 2'd1 : 2'd2;
      if (op[3] == 1'b0) begin e.rd = 1; has_dst = 1; dst = rt; end
      else e.wr = 1;
    end
    if (has_dst) begin
      e.dst = 5'(dst);
      e.we  = (dst != 0) && !e.ov;
    end
    return e;
  endfunction

  task automatic check(string why);
    obs_t exp_v = model(instr, rs_val, rt_val);
    obs_t act_v = '{result, dest_idx, rf_we, mem_addr, mem_rd, mem_wr, mem_size, ovf, illegal};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s instr=%08h a=%08h b=%08h actual=%h expected=%h",
               tag_of(instr), why, instr, rs_val, rt_val, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7fff_ffff;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      default: return $urandom();
    endcase
  endfunction

  function automatic int pick_reg();
    return ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 31));
  endfunction

  function automatic logic [31:0] pick_instr();
    logic [5:0] fns[10] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2a, 6'h2b};
    logic [5:0] ops[14] = '{6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0e, 6'h0f,
                            6'h20, 6'h21, 6'h23, 6'h28, 6'h29, 6'h2b};
    logic [15:0] imm;
    case ($urandom_range(0, 9))
      0, 1, 2, 3: return enc_r(pick_reg(), pick_reg(), pick_reg(), fns[$urandom_range(0, 9)]);
      4, 5, 6, 7: begin
        imm = ($urandom_range(0, 2) == 0) ? 16'hffff : 16'($urandom());
        return enc_i(ops[$urandom_range(0, 13)], pick_reg(), pick_reg(), imm);
      end
      default: return $urandom();
    endcase
  endfunction

  task automatic push(logic [31:0] i, logic [31:0] a, logic [31:0] b);
    vec_t v;
    v.i = i; v.a = a; v.b = b;
    vq.push_back(v);
  endtask

  initial begin
    // Directed vectors first
    push(enc_r(1, 2, 3, 6'h20), 32'd5, 32'd7);                 // R1 add
    push(enc_r(1, 2, 3, 6'h22), 32'd5, 32'd7);                 // R1 sub
    push(enc_r(1, 2, 4, 6'h27), 32'h0f0f_0000, 32'h0000_00f0); // R2 nor
    push(enc_r(1, 2, 5, 6'h2a), 32'hffff_ffff, 32'd1);         // R3 signed -> 1
    push(enc_r(1, 2, 5, 6'h2b), 32'hffff_ffff, 32'd1);         // R3 unsigned -> 0
    push(enc_r(1, 2, 3, 6'h20), 32'h7fff_ffff, 32'd1);         // R9 add overflow
    push(enc_r(1, 2, 3, 6'h21), 32'h7fff_ffff, 32'd1);         // R9 addu no flag
    push(enc_r(1, 2, 3, 6'h22), 32'h8000_0000, 32'd1);         // R9 sub overflow
    push(enc_i(6'h08, 1, 6, 16'hffff), 32'd10, 32'd0);         // R4 addi -1 -> 9
    push(enc_i(6'h08, 1, 6, 16'h0001), 32'h7fff_ffff, 32'd0);  // R9 addi overflow
    push(enc_i(6'h0b, 1, 6, 16'hffff), 32'd5, 32'd0);          // R4 sltiu -> 1
    push(enc_i(6'h0a, 1, 6, 16'hffff), 32'd5, 32'd0);          // R4 slti -> 0
    push(enc_i(6'h0c, 1, 7, 16'hffff), 32'hffff_ffff, 32'd0);  // R5 andi -> 0000ffff
    push(enc_i(6'h0f, 9, 8, 16'h003d), 32'h1234_5678, 32'd0);  // R6 upper imm
    push(enc_i(6'h23, 1, 8, 16'hfffc), 32'h0000_1000, 32'd0);  // R7 word load
    push(enc_i(6'h21, 1, 0, 16'h0002), 32'h0000_1000, 32'd0);  // R7/R10 load to reg 0
    push(enc_i(6'h28, 1, 8, 16'h0010), 32'h0000_2000, 32'd3);  // R8 byte store
    push(enc_r(1, 2, 0, 6'h20), 32'd1, 32'd1);                 // R10 zero rd
    push(32'hfc00_0000, 32'd1, 32'd1);                         // R11 opcode 111111
    push(enc_r(1, 2, 3, 6'h00), 32'd1, 32'd1);                 // R11 funct 0
    push(enc_r(1, 2, 3, 6'h20) | 32'h0000_0040, 32'd1, 32'd1); // R11 nonzero shamt
    for (int k = 0; k < N_RANDOM; k++) push(pick_instr(), pick_val(), pick_val());

    // Reset phase: all-zero word is illegal (R11)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset-state");
    rst = 1'b0;

    while (vq.size() > 0) begin
      vec_t v;
      v = vq.pop_front();
      @(posedge clk);
      #1;
      instr = v.i; rs_val = v.a; rt_val = v.b;
      @(negedge clk);
      check("vector");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule